// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Timer

This block is a pulse-width modulation timer with eight output channels. One free-running up-counter sets the period for every channel. Each channel compares that count with its own threshold and drives one output pin. The counter steps on enable strobes that come from one of three tick sources in the clock domain of `clk`. A power-of-two prescaler divides the selected source. The counter counts from a start value up to a limit and then returns to the start value.

Software programs the block through a flat word-addressed register port. Writes are synchronous and reads are combinational. Each channel has its own settings: an output mode, an inversion bit, a mask bit and an optional enable bit. A lock register guards the settings that define the shared timebase and the shape of each output. The period limit and the channel thresholds are double-buffered, so a running waveform only takes up a new value at a period boundary.

Top module: `pwm_shared_timer`

Register map (word addresses): 0 control, 1 period limit, 2 start value, 3 mask, 4 invert, 5 lock, 6 unlock, 7 count (read only). Address 8+2n holds the mode of channel n and address 9+2n holds its threshold.

## Requirements
- R1: After reset, every output is low. The mask reads 0xFF, the lock reads 0, and the control register reads 0 (counter stopped, prescale 0, channel enables clear).
- R2: Control bits [1:0] select the tick source: 1 = `tick_sys`, 2 = `tick_fix`, 3 = `tick_ext`. A value of 0 holds the counter at its current value.
- R3: Control bits [4:2] hold a prescale code p. The counter advances once every 2^p strobes of the selected source.
- R4: The counter counts from the start value (address 2) up to the period limit (address 1), then wraps to the start value. One period therefore lasts limit+1-start counter steps.
- R5: All channels share one period. Each channel has its own 16-bit threshold.
- R6: Mode bits [1:0] select the channel output. 2'b11 drives high while count < threshold and low otherwise. 2'b10 gives the complement of that. Any mode with bit 1 clear gives a raw level of 0.
- R7: In mode 2'b11, a threshold of 0 gives 0% duty. A threshold greater than the period limit gives 100% duty.
- R8: Setting bit n of the invert register inverts the output of channel n.
- R9: Setting bit n of the mask register forces output n low, whatever its inversion. A write to the mask register always takes effect.
- R10: Writing 1 to bit 0 of address 5 sets the lock. While the lock is set, the block ignores writes to the source and prescale fields, the period limit, the start value, the invert register and the channel modes. Writes to the thresholds, the mask and the channel enables still take effect.
- R11: Writing 1 to bit 0 of address 6 clears the lock. Nothing else clears it except reset.
- R12: While the counter runs, a new period limit or threshold takes effect only when the counter wraps. While the counter is stopped, new values take effect at once.
- R13: With channel enables built in, control bit 16+n must be set for channel n to drive its waveform. While it is clear, output n stays low.
- R14: Address 7 reads the current counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_sys | input | 1 | Tick strobe for source 1 |
| tick_fix | input | 1 | Tick strobe for source 2 |
| tick_ext | input | 1 | Tick strobe for source 3 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| pwm_out | output | 8 | Channel outputs |

## Verification
A wrong prescaler or counter-limit state shows up as a high-time count that differs from the expected value. This difference appears within one output period. The bench measures each channel's high cycles over a window of exactly two periods, so the result does not depend on where the window starts. A failed double-buffer shows up within a few cycles: the count read back falls to zero early, before it reaches the old limit. A lock that stays set or clears on its own shows up as a wrong readback on the next access.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    localparam int PS_W   = 3;
    localparam int DIV_W  = (1 << PS_W) - 1;

    typedef enum logic [1:0] {
        SRC_STOP = 2'd0,
        SRC_SYS  = 2'd1,
        SRC_FIX  = 2'd2,
        SRC_EXT  = 2'd3
    } src_e;

    typedef struct packed {
        logic [1:0] mode;
        logic       inv;
        logic       mask;
        logic       en;
    } chan_cfg_t;

    localparam logic [ADDR_W-1:0] RA_CTRL   = 5'd0;
    localparam logic [ADDR_W-1:0] RA_PERIOD = 5'd1;
    localparam logic [ADDR_W-1:0] RA_START  = 5'd2;
    localparam logic [ADDR_W-1:0] RA_MASK   = 5'd3;
    localparam logic [ADDR_W-1:0] RA_INVERT = 5'd4;
    localparam logic [ADDR_W-1:0] RA_LOCK   = 5'd5;
    localparam logic [ADDR_W-1:0] RA_UNLOCK = 5'd6;
    localparam logic [ADDR_W-1:0] RA_COUNT  = 5'd7;
    localparam int                CH_BASE   = 8;
    localparam int                EN_LSB    = 16;

    // Pin level from the shared count, the live threshold and the channel setup.
    function automatic logic chan_level(input logic [CNT_W-1:0] cnt,
                                        input logic [CNT_W-1:0] thr,
                                        input chan_cfg_t        c);
        logic below;
        logic raw;
        below = (cnt < thr);
        raw   = c.mode[1] ? (c.mode[0] ? below : ~below) : 1'b0;
        return (c.mask | ~c.en) ? 1'b0 : (raw ^ c.inv);
    endfunction
endpackage

// File: rtl/pwmt_tick.sv
module pwmt_tick
    import pwmt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  src_e            src,
    input  logic [PS_W-1:0] ps,
    input  logic [2:0]      strobes,
    output logic            adv
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;
    logic             tick;

    assign lim = DIV_W'((DIV_W+1)'(1) << ps) - DIV_W'(1);

    always_comb begin
        case (src)
            SRC_SYS: tick = strobes[0];
            SRC_FIX: tick = strobes[1];
            SRC_EXT: tick = strobes[2];
            default: tick = 1'b0;
        endcase
    end

    assign adv = tick && (div_q >= lim);

    always_ff @(posedge clk) begin
        if (rst || src == SRC_STOP) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= adv ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         stopped,
    input  logic [W-1:0] limit_buf,
    input  logic [W-1:0] start_val,
    output logic [W-1:0] count,
    output logic         load
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] lim_q;
    logic         wrap;

    assign wrap  = adv && (cnt_q >= lim_q);
    assign load  = stopped || wrap;
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= '1;
        end else begin
            if (adv)  cnt_q <= wrap ? start_val : cnt_q + 1'b1;
            if (load) lim_q <= limit_buf;
        end
    end
endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
    import pwmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] thr_buf,
    input  logic [CNT_W-1:0] cnt,
    input  chan_cfg_t        cfg,
    output logic             level
);
    logic [CNT_W-1:0] thr_q;

    always_ff @(posedge clk) begin
        if (rst)       thr_q <= '0;
        else if (load) thr_q <= thr_buf;
    end

    assign level = chan_level(cnt, thr_q, cfg);
endmodule

// File: rtl/pwm_shared_timer.sv
module pwm_shared_timer
    import pwmt_pkg::*;
#(
    parameter int NCH       = 8,
    parameter bit HAS_CH_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_sys,
    input  logic              tick_fix,
    input  logic              tick_ext,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NCH-1:0]    pwm_out
);
    localparam logic [NCH-1:0] EN_RST = HAS_CH_EN ? '0 : '1;

    src_e                       src_q;
    logic [PS_W-1:0]            ps_q;
    logic [NCH-1:0]             chen_q;
    logic [CNT_W-1:0]           mod_buf;
    logic [CNT_W-1:0]           init_q;
    logic [NCH-1:0]             mask_q;
    logic [NCH-1:0]             inv_q;
    logic                       lock_q;
    logic [NCH-1:0][1:0]        mode_q;
    logic [NCH-1:0][CNT_W-1:0]  thr_buf;

    logic             adv;
    logic             load;
    logic [CNT_W-1:0] cnt;
    logic             unused_wdata;

    assign unused_wdata = ^wdata;

    // Register writes, with the lock gating the timebase and shape fields
    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= SRC_STOP;
            ps_q    <= '0;
            chen_q  <= EN_RST;
            mod_buf <= '1;
            init_q  <= '0;
            mask_q  <= '1;
            inv_q   <= '0;
            lock_q  <= 1'b0;
            mode_q  <= '0;
            thr_buf <= '0;
        end else if (wr_en) begin
            if (addr == RA_CTRL) begin
                if (!lock_q) begin
                    src_q <= src_e'(wdata[1:0]);
                    ps_q  <= wdata[2 +: PS_W];
                end
                if (HAS_CH_EN) chen_q <= wdata[EN_LSB +: NCH];
            end
            if (addr == RA_PERIOD && !lock_q) mod_buf <= wdata[CNT_W-1:0];
            if (addr == RA_START  && !lock_q) init_q  <= wdata[CNT_W-1:0];
            if (addr == RA_INVERT && !lock_q) inv_q   <= wdata[NCH-1:0];
            if (addr == RA_MASK)              mask_q  <= wdata[NCH-1:0];
            if (addr == RA_LOCK   && wdata[0])           lock_q <= 1'b1;
            if (addr == RA_UNLOCK && wdata[0] && lock_q) lock_q <= 1'b0;
            for (int n = 0; n < NCH; n++) begin
                if (addr == ADDR_W'(CH_BASE + 2*n) && !lock_q) mode_q[n]  <= wdata[1:0];
                if (addr == ADDR_W'(CH_BASE + 2*n + 1))        thr_buf[n] <= wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_CTRL:   rdata = {{(DATA_W-EN_LSB-NCH){1'b0}}, chen_q,
                                {(EN_LSB-PS_W-2){1'b0}}, ps_q, src_q};
            RA_PERIOD: rdata = DATA_W'(mod_buf);
            RA_START:  rdata = DATA_W'(init_q);
            RA_MASK:   rdata = DATA_W'(mask_q);
            RA_INVERT: rdata = DATA_W'(inv_q);
            RA_LOCK:   rdata = DATA_W'(lock_q);
            RA_COUNT:  rdata = DATA_W'(cnt);
            default: begin
                for (int n = 0; n < NCH; n++) begin
                    if (addr == ADDR_W'(CH_BASE + 2*n))     rdata = DATA_W'(mode_q[n]);
                    if (addr == ADDR_W'(CH_BASE + 2*n + 1)) rdata = DATA_W'(thr_buf[n]);
                end
            end
        endcase
    end

    pwmt_tick u_tick (
        .clk     (clk),
        .rst     (rst),
        .src     (src_q),
        .ps      (ps_q),
        .strobes ({tick_ext, tick_fix, tick_sys}),
        .adv     (adv)
    );

    pwmt_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .stopped   (src_q == SRC_STOP),
        .limit_buf (mod_buf),
        .start_val (init_q),
        .count     (cnt),
        .load      (load)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        chan_cfg_t cfg;
        assign cfg = '{mode: mode_q[g], inv: inv_q[g], mask: mask_q[g], en: chen_q[g]};
        pwmt_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .load    (load),
            .thr_buf (thr_buf[g]),
            .cnt     (cnt),
            .cfg     (cfg),
            .level   (pwm_out[g])
        );
    end
endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker
    import pwmt_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              adv,
    input logic              load,
    input src_e              src_q,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  init_q,
    input logic              lock_q,
    input logic [CNT_W-1:0]  mod_buf,
    input logic [NCH-1:0]    mask_q,
    input logic [NCH-1:0]    pwm_out,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata
);
    logic unused_chk;
    assign unused_chk = ^wdata[DATA_W-1:1];

    p_stop_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (src_q == SRC_STOP) |=> $stable(cnt));

    p_adv_needs_src_r2: assert property (@(posedge clk) disable iff (rst)
        adv |-> (src_q != SRC_STOP));

    p_wrap_start_r4: assert property (@(posedge clk) disable iff (rst)
        (adv && load && src_q != SRC_STOP) |=> (cnt == $past(init_q)));

    p_mask_low_r9: assert property (@(posedge clk) disable iff (rst)
        ((mask_q & pwm_out) == '0));

    p_lock_period_r10: assert property (@(posedge clk) disable iff (rst)
        (lock_q && wr_en && addr == RA_PERIOD) |=> $stable(mod_buf));

    p_unlock_path_r11: assert property (@(posedge clk) disable iff (rst)
        ($fell(lock_q) && !$past(rst)) |-> $past(wr_en && addr == RA_UNLOCK && wdata[0]));
endmodule

bind pwm_shared_timer pwmt_checker #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .load    (load),
    .src_q   (src_q),
    .cnt     (cnt),
    .init_q  (init_q),
    .lock_q  (lock_q),
    .mod_buf (mod_buf),
    .mask_q  (mask_q),
    .pwm_out (pwm_out),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata)
);

// File: tb/tb_pwm_shared_timer.sv
`timescale 1ns/1ps
module tb_pwm_shared_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  pwm_out;
    int          phase = 0;
    logic        tick_sys, tick_fix, tick_ext;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 0;
    int          c_thr [8];
    int          c_mode[8];

    always #2 clk = ~clk;

    always @(posedge clk) phase <= phase + 1;
    assign tick_sys = 1'b1;
    assign tick_fix = (phase % 2) == 0;
    assign tick_ext = (phase % 3) == 0;

    pwm_shared_timer dut (
        .clk(clk), .rst(rst), .tick_sys(tick_sys), .tick_fix(tick_fix),
        .tick_ext(tick_ext), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pwm_out(pwm_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = a[4:0]; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        addr = a[4:0];
        #1 d = rdata;
    endtask

    function automatic int ctrl_word(input int src, input int ps, input int en);
        return (en << 16) | (ps << 2) | src;
    endfunction

    // High ticks per period from the requirements
    function automatic int exp_ticks(input int md, input int st, input int thr,
                                     input int mode, input int inv, input int msk, input int en);
        int p, h, raw;
        p = md + 1 - st;
        if (msk != 0 || en == 0) return 0;
        h   = (thr <= st) ? 0 : ((thr > md) ? p : thr - st);
        raw = ((mode & 2) == 0) ? 0 : (((mode & 1) != 0) ? h : p - h);
        return (inv != 0) ? p - raw : raw;
    endfunction

    task automatic run_case(input string tag, input int src, input int ps, input int md,
                            input int st, input int inv, input int msk, input int en);
        int pc;
        int hc[8];
        wr(0, ctrl_word(0, 0, en));
        wr(1, md); wr(2, st); wr(4, inv); wr(3, msk);
        for (int n = 0; n < 8; n++) begin
            wr(8 + 2*n, c_mode[n]);
            wr(9 + 2*n, c_thr[n]);
        end
        wr(0, ctrl_word(src, ps, en));
        pc = (md + 1 - st) * (1 << ps) * src;
        repeat (2*pc + 4) @(negedge clk);
        for (int n = 0; n < 8; n++) hc[n] = 0;
        for (int i = 0; i < 2*pc; i++) begin
            @(negedge clk);
            for (int n = 0; n < 8; n++) hc[n] += int'(pwm_out[n]);
        end
        for (int n = 0; n < 8; n++)
            chk(tag, hc[n], 2 * (1 << ps) * src *
                exp_ticks(md, st, c_thr[n], c_mode[n], (inv >> n) & 1, (msk >> n) & 1, (en >> n) & 1));
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int v, v2;
        void'($urandom(32'h5eed));
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        chk("R1 outputs", int'(pwm_out), 0);
        rd(3, v); chk("R1 mask", v, 8'hFF);
        rd(5, v); chk("R1 lock", v, 0);
        rd(0, v); chk("R1 ctrl", v, 0);

        // R2 / R14 stopped counter holds
        rd(7, v); repeat (5) @(negedge clk); rd(7, v2); chk("R2 R14 stopped count", v2, v);

        // R5 R6 R7: shared period, thresholds at the extremes
        c_thr = '{0, 1, 5, 9, 10, 11, 200, 3};
        foreach (c_mode[n]) c_mode[n] = 3;
        run_case("R5 R6 R7 sys", 1, 0, 9, 0, 0, 0, 8'hFF);

        // R2 R3 R6 R8: fixed source, prescale, mixed modes and inversion
        c_thr  = '{3, 3, 3, 3, 0, 0, 8, 5};
        c_mode = '{3, 2, 0, 1, 3, 2, 3, 0};
        run_case("R2 R3 R6 R8 fix", 2, 2, 7, 0, 8'b1000_0101, 0, 8'hFF);

        // R4: external source with nonzero start value
        c_thr = '{0, 4, 5, 6, 9, 10, 3, 7};
        foreach (c_mode[n]) c_mode[n] = 3;
        run_case("R4 R2 ext start", 3, 1, 9, 4, 0, 0, 8'hFF);

        // R9: mask beats inversion
        c_thr = '{5, 5, 5, 5, 5, 5, 5, 5};
        run_case("R9 mask", 1, 0, 9, 0, 8'hFF, 8'h33, 8'hFF);

        // R13: channel enables gate outputs
        run_case("R13 enable", 1, 1, 9, 0, 8'hF0, 0, 8'h0F);

        // Random mixes
        for (int it = 0; it < 6; it++) begin
            int md;
            md = 3 + int'($urandom % 38);
            foreach (c_thr[n]) begin
                c_thr[n]  = int'($urandom % (md + 4));
                c_mode[n] = int'($urandom % 4);
            end
            run_case("R5/R6/R8 random", 1 + int'($urandom % 3), int'($urandom % 4), md, 0,
                     int'($urandom % 256), int'($urandom % 256), 8'hFF);
        end

        // R10 R11: lock behaviour
        wr(0, ctrl_word(1, 0, 8'hFF));
        wr(1, 20); wr(4, 8'h0F); wr(8, 3); wr(2, 0);
        wr(5, 1);
        rd(5, v); chk("R10 lock set", v, 1);
        wr(1, 33);  rd(1, v); chk("R10 period ignored", v, 20);
        wr(4, 8'hF0); rd(4, v); chk("R10 invert ignored", v, 8'h0F);
        wr(8, 1);   rd(8, v); chk("R10 mode ignored", v, 3);
        wr(2, 5);   rd(2, v); chk("R10 start ignored", v, 0);
        wr(0, ctrl_word(2, 3, 8'hAA)); rd(0, v); chk("R10 ctrl fields", v, ctrl_word(1, 0, 8'hAA));
        wr(9, 7);   rd(9, v); chk("R10 threshold accepted", v, 7);
        wr(3, 8'h55); rd(3, v); chk("R10 R9 mask accepted", v, 8'h55);
        chk("R9 masked pins low", int'(pwm_out & 8'h55), 0);
        wr(6, 0);   rd(5, v); chk("R11 unlock needs bit", v, 1);
        wr(6, 1);   rd(5, v); chk("R11 unlocked", v, 0);
        wr(1, 33);  rd(1, v); chk("R11 period writable", v, 33);

        // R12: double-buffered limit while running
        wr(0, ctrl_word(0, 0, 8'hFF));
        wr(1, 20); wr(2, 0);
        wr(0, ctrl_word(1, 0, 8'hFF));
        v = -1;
        for (int i = 0; i < 100 && v != 15; i++) rd(7, v);
        wr(1, 9);
        rd(7, v); chk("R12 old limit still used", v, 18);
        v = -1;
        for (int i = 0; i < 100 && v != 0; i++) rd(7, v);
        v2 = 0;
        for (int i = 0; i < 10; i++) begin rd(7, v); if (v > v2) v2 = v; end
        chk("R12 R4 new limit after wrap", v2, 9);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule